// File: doc/BRIEF.md
# Parallel Port Configuration Register File

This block is the processor-facing register file of a three-port parallel I/O controller. A host reaches it through a chip select, separate read and write strobes, a two-bit address and a data bus of the port width. All of these are sampled on the system clock. A write to one of the three port addresses loads that port's output latch. A write to the fourth address is a control word. The top data bit decides how the rest of that word is read: either as a mode and direction definition for the two port groups, or as a command that sets or clears one bit of port C.

Group A is port A together with the upper half of port C. Group B is port B together with the lower half of port C. The block drives a per-pin output enable and an output value for all three ports. It also exports the mode of each group, so that a separate strobed-handshake unit can take over port C's control pins. Read data comes back one clock after a read is sampled. A data-valid flag stands in for the high-impedance state of a shared bus.

Top module: `ppi_cfg_regs`

## Requirements
- R1: A sampled write with address 00, 01 or 10 loads the whole data word into the output latch of port A, port B or port C, respectively. The latch shows on the matching pin output from the next clock.
- R2: A control write (address 11) with data bit 7 = 1 is a mode word, decoded as follows:
  - bits 6:5 give the group A mode. 00 selects mode 0, 01 selects mode 1, and 10 or 11 both report as mode 2 (2'b10) on `grp_a_mode`.
  - bit 2 gives the group B mode on `grp_b_mode`.
  - bit 4 sets the direction of port A, bit 3 the upper half of port C, bit 1 port B and bit 0 the lower half of port C. A direction bit of 1 means input (output enables low); 0 means output (output enables high).
- R3: While reset is high, and on the first cycle after it, all output enables are low, both modes are 0, all output latches are 0 and read data is not valid.
- R4: A control write with data bit 7 = 0 is a port C bit command. Bits 3:1 pick the port C bit and bit 0 gives its new value (1 sets it, 0 clears it). No other port C bit changes, and the modes and directions stay the same.
- R5: A mode word clears the output latches of ports A, B and C to 0 in the same clock edge.
- R6: Read data and `bus_rdata_en` become valid on the clock edge that samples a read, and stay valid while the read is held. For a port or port C half set as output, the read returns the output latch.
- R7: A read of port A or port B set as input returns the pin value taken on the first sampled cycle of the read. That value holds while the read continues, even if the pins change.
- R8: A read of a port C half set as input returns the pin value sampled at each clock edge of the read.
- R9: `bus_rdata_en` stays low and `bus_rdata` stays 0 after a cycle with any of the following: chip select low, neither strobe active, both strobes active, or a read at address 11.
- R10: A write is ignored, leaving all latches, directions and modes unchanged, when chip select is low or when read and write are both active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Chip select, active high |
| bus_rd | input | 1 | Read strobe, active high |
| bus_wr | input | 1 | Write strobe, active high |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | PW | Write data |
| bus_rdata | output | PW | Read data, 0 when not valid |
| bus_rdata_en | output | 1 | Read data valid (bus driven) |
| pa_in | input | PW | Port A pin input |
| pa_out | output | PW | Port A output latch |
| pa_oe | output | PW | Port A output enables |
| pb_in | input | PW | Port B pin input |
| pb_out | output | PW | Port B output latch |
| pb_oe | output | PW | Port B output enables |
| pc_in | input | PW | Port C pin input |
| pc_out | output | PW | Port C output latch |
| pc_oe | output | PW | Port C output enables, per half |
| grp_a_mode | output | 2 | Group A mode (0, 1 or 2) |
| grp_b_mode | output | 1 | Group B mode (0 or 1) |

## Verification
Some rules can be checked on every cycle, and the assertions cover those:
- the state just after reset;
- the clear of all latches that follows a mode word;
- a bit command changing at most one port C bit and no configuration;
- the data-valid flag staying low after any cycle without a legal read;
- the captured port A value holding steady through a long read.

Other behaviour depends on the values the host writes and the pins present, so only the bench's scenarios can show it:
- the address decode;
- the exact field positions of the mode word, including the folding of group A mode 11 into mode 2;
- choosing the output latch or the pin value by direction on a read;
- live versus captured pin data;
- writes that are dropped.

// File: rtl/ppi_pkg.sv
package ppi_pkg;
  typedef enum logic [1:0] {
    SEL_A   = 2'b00,
    SEL_B   = 2'b01,
    SEL_C   = 2'b10,
    SEL_CTL = 2'b11
  } port_sel_e;

  // Group configuration; direction fields use 1 = input.
  typedef struct packed {
    logic [1:0] a_mode;
    logic       a_in;
    logic       cu_in;
    logic       b_mode;
    logic       b_in;
    logic       cl_in;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{a_mode: 2'b00, a_in: 1'b1, cu_in: 1'b1,
                                 b_mode: 1'b0, b_in: 1'b1, cl_in: 1'b1};
endpackage

// File: rtl/ppi_bus_decode.sv
module ppi_bus_decode
  import ppi_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sel,
  input  logic       rd,
  input  logic       wr,
  input  logic [1:0] addr,
  input  logic       ctl_top,
  output logic       wr_a,
  output logic       wr_b,
  output logic       wr_c,
  output logic       wr_mode,
  output logic       wr_bsr,
  output logic       rd_ok,
  output logic       rd_start
);
  logic wr_ok;
  logic rd_ok_q;

  assign wr_ok   = sel && wr && !rd;
  assign wr_a    = wr_ok && (addr == SEL_A);
  assign wr_b    = wr_ok && (addr == SEL_B);
  assign wr_c    = wr_ok && (addr == SEL_C);
  assign wr_mode = wr_ok && (addr == SEL_CTL) && ctl_top;
  assign wr_bsr  = wr_ok && (addr == SEL_CTL) && !ctl_top;

  assign rd_ok    = sel && rd && !wr && (addr != SEL_CTL);
  assign rd_start = rd_ok && !rd_ok_q;

  always_ff @(posedge clk) begin
    if (rst) rd_ok_q <= 1'b0;
    else     rd_ok_q <= rd_ok;
  end

  // R10: at most one write target per cycle
  a_r10_one_target: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_a, wr_b, wr_c, wr_mode, wr_bsr}));
endmodule

// File: rtl/ppi_ctrl_reg.sv
module ppi_ctrl_reg
  import ppi_pkg::*;
#(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_a,
  input  logic          wr_b,
  input  logic          wr_c,
  input  logic          wr_mode,
  input  logic          wr_bsr,
  input  logic [PW-1:0] wdata,
  output cfg_t          cfg,
  output logic [PW-1:0] pa_q,
  output logic [PW-1:0] pb_q,
  output logic [PW-1:0] pc_q
);
  localparam int IDX_W = $clog2(PW);

  logic [IDX_W-1:0] bit_idx;
  assign bit_idx = wdata[IDX_W:1];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg  <= CFG_RESET;
      pa_q <= '0;
      pb_q <= '0;
      pc_q <= '0;
    end else if (wr_mode) begin
      cfg.a_mode <= wdata[6] ? 2'b10 : {1'b0, wdata[5]};
      cfg.a_in   <= wdata[4];
      cfg.cu_in  <= wdata[3];
      cfg.b_mode <= wdata[2];
      cfg.b_in   <= wdata[1];
      cfg.cl_in  <= wdata[0];
      pa_q <= '0;
      pb_q <= '0;
      pc_q <= '0;
    end else begin
      if (wr_a) pa_q <= wdata;
      if (wr_b) pb_q <= wdata;
      if (wr_c) pc_q <= wdata;
      if (wr_bsr) pc_q[bit_idx] <= wdata[0];
    end
  end

  // R3: every port is an input right after reset
  a_r3_reset_inputs: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cfg == CFG_RESET && pa_q == '0 && pb_q == '0 && pc_q == '0));

  // R5: mode word leaves all latches cleared
  a_r5_mode_clears: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_mode)) |-> (pa_q == '0 && pb_q == '0 && pc_q == '0));

  // R4: bit command touches at most one port C bit and no configuration
  a_r4_bsr_single_bit: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_bsr)) |->
      ($countones(pc_q ^ $past(pc_q)) <= 1 && $stable(cfg) &&
       $stable(pa_q) && $stable(pb_q)));
endmodule

// File: rtl/ppi_read_mux.sv
module ppi_read_mux
  import ppi_pkg::*;
#(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_ok,
  input  logic          rd_start,
  input  logic [1:0]    addr,
  input  logic          a_in,
  input  logic          b_in,
  input  logic          cu_in,
  input  logic          cl_in,
  input  logic [PW-1:0] pa_q,
  input  logic [PW-1:0] pb_q,
  input  logic [PW-1:0] pc_q,
  input  logic [PW-1:0] pa_pin,
  input  logic [PW-1:0] pb_pin,
  input  logic [PW-1:0] pc_pin,
  output logic [PW-1:0] rdata,
  output logic          rdata_en
);
  localparam int HALF = PW / 2;

  logic [PW-1:0] pa_cap, pb_cap;
  logic [PW-1:0] pa_view, pb_view, pc_view, rd_mux;

  assign pa_view = rd_start ? pa_pin : pa_cap;
  assign pb_view = rd_start ? pb_pin : pb_cap;
  assign pc_view = {cu_in ? pc_pin[PW-1:HALF] : pc_q[PW-1:HALF],
                    cl_in ? pc_pin[HALF-1:0]  : pc_q[HALF-1:0]};

  always_comb begin
    case (addr)
      SEL_A:   rd_mux = a_in ? pa_view : pa_q;
      SEL_B:   rd_mux = b_in ? pb_view : pb_q;
      SEL_C:   rd_mux = pc_view;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_en <= 1'b0;
      rdata    <= '0;
      pa_cap   <= '0;
      pb_cap   <= '0;
    end else begin
      rdata_en <= rd_ok;
      rdata    <= rd_ok ? rd_mux : '0;
      if (rd_start) begin
        pa_cap <= pa_pin;
        pb_cap <= pb_pin;
      end
    end
  end

  // R9: no legal read sampled means the bus stays released
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_ok) |-> (!rdata_en && rdata == '0));

  // R7: a continued read of input port A keeps its captured value
  a_r7_capture_hold: assert property (@(posedge clk) disable iff (rst)
    (rd_ok && !rd_start && $past(rd_ok) && $stable(addr) && addr == SEL_A &&
     a_in && $stable(a_in)) |=> $stable(rdata));
endmodule

// File: rtl/ppi_cfg_regs.sv
module ppi_cfg_regs
  import ppi_pkg::*;
#(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_sel,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [1:0]    bus_addr,
  input  logic [PW-1:0] bus_wdata,
  output logic [PW-1:0] bus_rdata,
  output logic          bus_rdata_en,
  input  logic [PW-1:0] pa_in,
  output logic [PW-1:0] pa_out,
  output logic [PW-1:0] pa_oe,
  input  logic [PW-1:0] pb_in,
  output logic [PW-1:0] pb_out,
  output logic [PW-1:0] pb_oe,
  input  logic [PW-1:0] pc_in,
  output logic [PW-1:0] pc_out,
  output logic [PW-1:0] pc_oe,
  output logic [1:0]    grp_a_mode,
  output logic          grp_b_mode
);
  localparam int HALF = PW / 2;

  logic wr_a, wr_b, wr_c, wr_mode, wr_bsr, rd_ok, rd_start;
  cfg_t cfg;

  ppi_bus_decode u_dec (
    .clk(clk), .rst(rst), .sel(bus_sel), .rd(bus_rd), .wr(bus_wr),
    .addr(bus_addr), .ctl_top(bus_wdata[PW-1]),
    .wr_a(wr_a), .wr_b(wr_b), .wr_c(wr_c), .wr_mode(wr_mode),
    .wr_bsr(wr_bsr), .rd_ok(rd_ok), .rd_start(rd_start)
  );

  ppi_ctrl_reg #(.PW(PW)) u_ctrl (
    .clk(clk), .rst(rst), .wr_a(wr_a), .wr_b(wr_b), .wr_c(wr_c),
    .wr_mode(wr_mode), .wr_bsr(wr_bsr), .wdata(bus_wdata),
    .cfg(cfg), .pa_q(pa_out), .pb_q(pb_out), .pc_q(pc_out)
  );

  ppi_read_mux #(.PW(PW)) u_rd (
    .clk(clk), .rst(rst), .rd_ok(rd_ok), .rd_start(rd_start),
    .addr(bus_addr), .a_in(cfg.a_in), .b_in(cfg.b_in),
    .cu_in(cfg.cu_in), .cl_in(cfg.cl_in),
    .pa_q(pa_out), .pb_q(pb_out), .pc_q(pc_out),
    .pa_pin(pa_in), .pb_pin(pb_in), .pc_pin(pc_in),
    .rdata(bus_rdata), .rdata_en(bus_rdata_en)
  );

  assign pa_oe      = {PW{~cfg.a_in}};
  assign pb_oe      = {PW{~cfg.b_in}};
  assign pc_oe      = {{(PW-HALF){~cfg.cu_in}}, {HALF{~cfg.cl_in}}};
  assign grp_a_mode = cfg.a_mode;
  assign grp_b_mode = cfg.b_mode;

  // R2: group A never reports the unused mode code 11
  a_r2_mode_legal: assert property (@(posedge clk) disable iff (rst)
    grp_a_mode != 2'b11);
endmodule

// File: tb/ppi_cfg_regs_bench.sv
module ppi_cfg_regs_bench;
  localparam int PW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_sel = 0, bus_rd = 0, bus_wr = 0;
  logic [1:0]    bus_addr = 0;
  logic [PW-1:0] bus_wdata = 0;
  logic [PW-1:0] bus_rdata;
  logic          bus_rdata_en;
  logic [PW-1:0] pa_in = 0, pb_in = 0, pc_in = 0;
  logic [PW-1:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;
  logic [1:0]    grp_a_mode;
  logic          grp_b_mode;

  int n_chk = 0;
  int n_fail = 0;

  // bench model
  logic [7:0] m_pa = 0, m_pb = 0, m_pc = 0;
  logic       m_ain = 1, m_cuin = 1, m_bin = 1, m_clin = 1, m_bmode = 0;
  logic [1:0] m_amode = 0;

  always #4 clk = ~clk;

  ppi_cfg_regs #(.PW(PW)) u_ppi_cfg_regs (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rdata_en(bus_rdata_en), .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe), .pc_in(pc_in),
    .pc_out(pc_out), .pc_oe(pc_oe), .grp_a_mode(grp_a_mode),
    .grp_b_mode(grp_b_mode)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [1:0] a);
    case (a)
      2'b00:   return m_ain ? pa_in : m_pa;
      2'b01:   return m_bin ? pb_in : m_pb;
      2'b10:   return {m_cuin ? pc_in[7:4] : m_pc[7:4], m_clin ? pc_in[3:0] : m_pc[3:0]};
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [31:0] exp_oe();
    return {8'h0, {8{~m_ain}}, {8{~m_bin}}, {{4{~m_cuin}}, {4{~m_clin}}}};
  endfunction

  task automatic model_write(input logic [1:0] a, input logic [7:0] d);
    case (a)
      2'b00: m_pa = d;
      2'b01: m_pb = d;
      2'b10: m_pc = d;
      default: begin
        if (d[7]) begin
          m_amode = d[6] ? 2'b10 : {1'b0, d[5]};
          m_ain = d[4]; m_cuin = d[3]; m_bmode = d[2]; m_bin = d[1]; m_clin = d[0];
          m_pa = 0; m_pb = 0; m_pc = 0;
        end else begin
          m_pc[d[3:1]] = d[0];
        end
      end
    endcase
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    model_write(a, d);
  endtask

  task automatic check_state(input string tag);
    check({pa_out, pb_out, pc_out}, {m_pa, m_pb, m_pc}, {tag, " latches"});
    check({8'h0, pa_oe, pb_oe, pc_oe}, exp_oe(), {tag, " enables"});
    check({grp_a_mode, grp_b_mode}, {m_amode, m_bmode}, {tag, " modes"});
  endtask

  task automatic bus_read(input logic [1:0] a, input string tag);
    logic [7:0] e;
    @(negedge clk);
    bus_sel = 1; bus_rd = 1; bus_addr = a;
    e = exp_read(a);
    @(negedge clk);
    check({bus_rdata_en, bus_rdata}, {1'b1, e}, tag);
    bus_sel = 0; bus_rd = 0;
    @(negedge clk);
    check({bus_rdata_en, bus_rdata}, 9'h000, "R9 released after read");
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] hold;
    void'($urandom(32'h2c55));
    repeat (3) @(negedge clk);
    // R3 reset state, sampled during reset and just after release
    check_state("R3 in reset");
    check({bus_rdata_en, bus_rdata}, 9'h000, "R3 bus idle");
    rst = 0;
    @(negedge clk);
    check_state("R3 after reset");

    // R2 all-output mode word, R1 port writes and reads
    bus_write(2'b11, 8'h80);
    check_state("R2 all output");
    bus_write(2'b00, 8'h5A);
    bus_write(2'b01, 8'hC3);
    bus_write(2'b10, 8'h96);
    check({pa_out, pb_out, pc_out}, 24'h5AC396, "R1 port latches");
    bus_read(2'b00, "R6 read A latch");
    bus_read(2'b01, "R6 read B latch");
    bus_read(2'b10, "R6 read C latch");

    // R4 bit commands
    bus_write(2'b11, 8'h07);
    check(pc_out, 8'h9E, "R4 set bit 3");
    bus_write(2'b11, 8'h0E);
    check(pc_out, 8'h1E, "R4 clear bit 7");
    check_state("R4 config kept");

    // R2 field decode incl. mode 11 -> 2, R5 clear
    bus_write(2'b11, 8'hE5);
    check({grp_a_mode, grp_b_mode}, 3'b101, "R2 mode 11 folds to 2");
    check({pa_out, pb_out, pc_out}, 24'h0, "R5 latches cleared");
    check_state("R2 mixed word");

    // R7 captured A, R8 live C: all input
    bus_write(2'b11, 8'h9B);
    pa_in = 8'h11; pc_in = 8'h3C;
    @(negedge clk);
    bus_sel = 1; bus_rd = 1; bus_addr = 2'b00;
    @(negedge clk);
    check(bus_rdata, 8'h11, "R7 first sample");
    pa_in = 8'h22;
    @(negedge clk);
    check(bus_rdata, 8'h11, "R7 held capture");
    bus_addr = 2'b10;
    @(negedge clk);
    check(bus_rdata, 8'h3C, "R8 C pins");
    pc_in = 8'hA5;
    @(negedge clk);
    check(bus_rdata, 8'hA5, "R8 C live update");
    bus_sel = 0; bus_rd = 0;

    // R10 ignored writes, R9 quiet bus
    bus_write(2'b11, 8'h80);
    bus_write(2'b00, 8'h77);
    @(negedge clk);
    bus_sel = 0; bus_wr = 1; bus_addr = 2'b00; bus_wdata = 8'hEE;
    @(negedge clk);
    check(pa_out, 8'h77, "R10 write without select");
    check({bus_rdata_en, bus_rdata}, 9'h000, "R9 no select");
    bus_sel = 1; bus_rd = 1;
    @(negedge clk);
    check(pa_out, 8'h77, "R10 both strobes");
    check({bus_rdata_en, bus_rdata}, 9'h000, "R9 both strobes");
    bus_wr = 0; bus_addr = 2'b11;
    @(negedge clk);
    check({bus_rdata_en, bus_rdata}, 9'h000, "R9 read of address 11");
    bus_rd = 0;
    @(negedge clk);
    check({bus_rdata_en, bus_rdata}, 9'h000, "R9 select without strobe");
    bus_sel = 0;
    check_state("R10 state kept");

    // random mix
    for (int i = 0; i < 400; i++) begin
      int op;
      op = $urandom % 4;
      pa_in = 8'($urandom); pb_in = 8'($urandom); pc_in = 8'($urandom);
      case (op)
        0: begin
          bus_write(2'($urandom % 3), 8'($urandom));
          check_state("R1 random port write");
        end
        1: begin
          hold = 8'($urandom);
          bus_write(2'b11, hold);
          check_state(hold[7] ? "R2 random mode word" : "R4 random bit command");
        end
        default: bus_read(2'($urandom % 3), "R6 random read");
      endcase
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule